// File: doc/BRIEF.md
# Host Mailbox FIFO Register Block

This block sits between a host register bus and an embedded controller's byte stream. The host sees a window of eight 32-bit words. Three of them are used: an interrupt word, a data word and a status word. A host write to the data word queues one byte toward the controller. A host read of the data word takes the oldest byte the controller has sent. Each direction is buffered in its own FIFO.

On the controller side, outgoing bytes leave through a valid/ready pair. Incoming bytes arrive on a valid strobe that has no backpressure. A byte offered while the receive FIFO is full is lost, and that loss is recorded as an overflow.

Four event sources each latch a request flag and each have an enable mask. The interrupt line rises when any enabled request is pending. Host writes of ones to the status word clear the sticky flags.

Top module: `mbox_regif`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), both FIFOs are empty, all masks and request flags are zero and irq is low. Two cycles later, the status word (word 2) reads 0x03 and the interrupt word (word 0) reads 0x03.
- R2: A host write to word 1 queues bits 15:8 of the write data into the transmit FIFO and ignores all other bits. Queued bytes appear on ctl_tx_data in write order, with ctl_tx_valid high while the FIFO holds any byte. A byte leaves on each rising edge where ctl_tx_valid and ctl_tx_ready are both high.
- R3: The transmit FIFO holds 8 bytes. A data write while it holds 8 is dropped. With 8 held, status bit 0 (transmit empty) and status bit 1 (transmit not full) both read 0.
- R4: A host read of word 1 removes the oldest received byte and returns it in bits 15:8, with every other bit zero. Read data is registered and valid one cycle after the access. Status bit 2 (receive not empty) is 1 while the receive FIFO holds a byte.
- R5: A read of word 1 while the receive FIFO is empty returns zero and leaves the FIFO unchanged.
- R6: The receive FIFO holds 8 bytes. A byte offered on ctl_rx_valid while it holds 8 is dropped, and status bit 3 (receive overflow) sets and stays set.
- R7: Writing the status word with bit n set clears request flag n. For n = 3 this also clears the sticky overflow status. A source whose condition is still true in that same cycle stays set.
- R8: A write to word 0 loads its bits 7:4 as the masks for request flags 3:0 and ignores bits 3:0. Word 0 reads as {masks, request flags} in bits 7:0.
- R9: irq is high whenever some request flag and its mask bit are both 1. It follows the flags and masks with no extra delay.
- R10: Request flags 0 to 2 latch at the first rising edge after their live condition is true. The flags are transmit empty, transmit not full and receive not empty, in that order.
- R11: Words 3 to 7 read as zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Host access strobe, one access per cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Word index in the 8-word window |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Registered host read data |
| ctl_tx_valid | output | 1 | Transmit FIFO has a byte for the controller |
| ctl_tx_ready | input | 1 | Controller takes the byte this cycle |
| ctl_tx_data | output | 8 | Oldest transmit byte |
| ctl_rx_valid | input | 1 | Controller offers a byte this cycle |
| ctl_rx_data | input | 8 | Byte offered by the controller |
| irq | output | 1 | Any enabled request pending |

## Verification
A register read is due in the cycle after its access edge. A write shows up in the FIFO state and in the masks right after its edge. Request flags fed by live FIFO conditions take one more edge, and irq follows the flags with no added cycle.

Every bus and controller-side stimulus is driven on a falling edge. Results are sampled 1 ns after the rising edge that acts on them. The irq rise after a received byte is therefore checked at two points: low after the push edge and high after the next edge. Overflow and full checks count the exact number of offered bytes, then drain the FIFO to show which byte was lost.

// File: rtl/mbox_pkg.sv
// Package mbox_pkg
// Shared constants for the host mailbox register block: window size,
// word offsets and the bit positions of the four event sources.
package mbox_pkg;
    localparam int          REG_WORDS = 8;
    localparam int          ADDR_W    = $clog2(REG_WORDS);
    localparam int          NUM_EV    = 4;
    localparam int          BYTE_W    = 8;
    localparam int          BYTE_LSB  = 8;

    localparam logic [ADDR_W-1:0] OFF_INTR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(2);

    localparam int EV_TXE  = 0;
    localparam int EV_TXNF = 1;
    localparam int EV_RXNE = 2;
    localparam int EV_RXO  = 3;
endpackage

// File: rtl/mbox_fifo.sv
// Module mbox_fifo
// Circular-buffer FIFO with first-word-fall-through head output.
// Assumes: a push while full is dropped even if a pop happens in the
// same cycle; a pop while empty is ignored. Synchronous active-low reset.
module mbox_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = store[rd_ptr];

    // Write accepted bytes into the buffer.
    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= push_data;
    end

    // Advance pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count));

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> $stable(count));
endmodule

// File: rtl/mbox_flags.sv
// Module mbox_flags
// Request flags, enable masks and the interrupt line.
// Assumes: cond[] is the event condition seen this cycle; a set from
// cond wins over a clear in the same cycle; irq is combinational from
// the flag and mask registers.
module mbox_flags #(
    parameter int NUM_EV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] cond,
    input  logic [NUM_EV-1:0] clr,
    input  logic              mask_we,
    input  logic [NUM_EV-1:0] mask_wdata,
    output logic [NUM_EV-1:0] req,
    output logic [NUM_EV-1:0] mask,
    output logic              irq
);
    // Latch request flags: clear by write-one, set by condition.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= '0;
        else        req <= (req & ~clr) | cond;
    end

    // Hold the per-source enable masks.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_wdata;
    end

    assign irq = |(req & mask);

    // R7
    for (genvar k = 0; k < NUM_EV; k++) begin : g_clr
        clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[k] && !cond[k]) |=> !req[k]);
    end

    // R6
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond[NUM_EV-1] |=> req[NUM_EV-1]);

    // R9
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && mask_wdata == '0) |=> !irq);
endmodule

// File: rtl/mbox_regif.sv
// Module mbox_regif
// Host register window over a transmit FIFO and a receive FIFO, with
// four latched event requests and a maskable interrupt.
// Assumes: at most one host access per cycle; read data is registered;
// the controller receive path has no backpressure.
module mbox_regif
    import mbox_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              ctl_tx_valid,
    input  logic              ctl_tx_ready,
    output logic [7:0]        ctl_tx_data,
    input  logic              ctl_rx_valid,
    input  logic [7:0]        ctl_rx_data
    ,
    output logic              irq
);
    logic              wr, rd;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [BYTE_W-1:0] tx_head, rx_head, wr_byte;
    logic              ovf_evt;
    logic [NUM_EV-1:0] cond, clr, req, mask;
    logic [31:0]       stat_word, intr_word, data_word;
    logic              unused_wbits;

    assign wr      = bus_valid && bus_write;
    assign rd      = bus_valid && !bus_write;
    assign wr_byte = bus_wdata[BYTE_LSB +: BYTE_W];
    assign unused_wbits = ^bus_wdata[31:16];

    mbox_fifo #(.DEPTH(TX_DEPTH), .WIDTH(BYTE_W)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr && bus_addr == OFF_DATA),
        .push_data (wr_byte),
        .pop       (ctl_tx_ready),
        .head      (tx_head),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    mbox_fifo #(.DEPTH(RX_DEPTH), .WIDTH(BYTE_W)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ctl_rx_valid),
        .push_data (ctl_rx_data),
        .pop       (rd && bus_addr == OFF_DATA),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    assign ctl_tx_valid = !tx_empty;
    assign ctl_tx_data  = tx_head;
    assign ovf_evt      = ctl_rx_valid && rx_full;

    // Gather event conditions and write-one clears.
    always_comb begin
        cond          = '0;
        cond[EV_TXE]  = tx_empty;
        cond[EV_TXNF] = !tx_full;
        cond[EV_RXNE] = !rx_empty;
        cond[EV_RXO]  = ovf_evt;
        clr = (wr && bus_addr == OFF_STAT) ? bus_wdata[NUM_EV-1:0] : '0;
    end

    mbox_flags #(.NUM_EV(NUM_EV)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .cond       (cond),
        .clr        (clr),
        .mask_we    (wr && bus_addr == OFF_INTR),
        .mask_wdata (bus_wdata[2*NUM_EV-1:NUM_EV]),
        .req        (req),
        .mask       (mask),
        .irq        (irq)
    );

    // Assemble the readable words.
    always_comb begin
        intr_word = {24'b0, mask, req};
        stat_word = '0;
        stat_word[EV_TXE]  = tx_empty;
        stat_word[EV_TXNF] = !tx_full;
        stat_word[EV_RXNE] = !rx_empty;
        stat_word[EV_RXO]  = req[EV_RXO];
        data_word = '0;
        if (!rx_empty) data_word[BYTE_LSB +: BYTE_W] = rx_head;
    end

    // Register host read data on each read access.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else if (rd) begin
            case (bus_addr)
                OFF_INTR: bus_rdata <= intr_word;
                OFF_DATA: bus_rdata <= data_word;
                OFF_STAT: bus_rdata <= stat_word;
                default:  bus_rdata <= '0;
            endcase
        end
    end

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr > OFF_STAT) |=> bus_rdata == '0);

    // R5
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == OFF_DATA && rx_empty) |=> bus_rdata == '0);
endmodule

// File: tb/mbox_regif_tb.sv
module mbox_regif_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ctl_tx_valid, ctl_tx_ready = 1'b0;
    logic [7:0]  ctl_tx_data;
    logic        ctl_rx_valid = 1'b0;
    logic [7:0]  ctl_rx_data = '0;
    logic        irq;
    int          checks = 0, fails = 0;

    mbox_regif u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctl_tx_valid(ctl_tx_valid), .ctl_tx_ready(ctl_tx_ready),
        .ctl_tx_data(ctl_tx_data), .ctl_rx_valid(ctl_rx_valid),
        .ctl_rx_data(ctl_rx_data), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic rx_offer(input logic [7:0] b);
        @(negedge clk);
        ctl_rx_valid = 1'b1; ctl_rx_data = b;
        @(posedge clk); #1;
        ctl_rx_valid = 1'b0;
    endtask

    task automatic tx_take(output logic v, output logic [7:0] b);
        @(negedge clk);
        v = ctl_tx_valid; b = ctl_tx_data; ctl_tx_ready = 1'b1;
        @(posedge clk); #1;
        ctl_tx_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 tx_valid", 32'(ctl_tx_valid), 0);
        bus_rd(3'd2, d); chk("R1 status", d, 32'h03);
        bus_rd(3'd0, d); chk("R1 R10 intr", d, 32'h03);
    endtask

    task automatic t_tx_order();
        logic [31:0] d; logic v; logic [7:0] b;
        bus_wr(3'd1, 32'hFFFF_A1FF);
        bus_wr(3'd1, 32'h0000_B200);
        bus_wr(3'd1, 32'h1234_C356);
        bus_rd(3'd2, d); chk("R2 status with 3 queued", d, 32'h02);
        tx_take(v, b); chk("R2 byte0", {v, b}, {1'b1, 8'hA1});
        tx_take(v, b); chk("R2 byte1", {v, b}, {1'b1, 8'hB2});
        tx_take(v, b); chk("R2 byte2", {v, b}, {1'b1, 8'hC3});
        #1 chk("R2 drained", 32'(ctl_tx_valid), 0);
    endtask

    task automatic t_tx_full();
        logic [31:0] d; logic v; logic [7:0] b;
        for (int k = 0; k < 9; k++) bus_wr(3'd1, 32'(8'h10 + k) << 8);
        bus_rd(3'd2, d); chk("R3 status full", d, 32'h00);
        for (int k = 0; k < 8; k++) begin
            tx_take(v, b); chk("R3 drain", {v, b}, {1'b1, 8'(8'h10 + k)});
        end
        #1 chk("R3 ninth dropped", 32'(ctl_tx_valid), 0);
    endtask

    task automatic t_rx_basic();
        logic [31:0] d;
        rx_offer(8'h5A); rx_offer(8'h6B);
        bus_rd(3'd2, d); chk("R4 status rx", d, 32'h07);
        bus_rd(3'd1, d); chk("R4 read0", d, 32'h0000_5A00);
        bus_rd(3'd1, d); chk("R4 read1", d, 32'h0000_6B00);
        bus_rd(3'd1, d); chk("R5 empty read", d, 32'h0);
        bus_rd(3'd2, d); chk("R5 still empty", d, 32'h03);
    endtask

    task automatic t_rx_overflow();
        logic [31:0] d;
        for (int k = 0; k < 9; k++) rx_offer(8'(8'h80 + k));
        bus_rd(3'd2, d); chk("R6 status ovf", d, 32'h0F);
        bus_rd(3'd0, d); chk("R6 intr req", d, 32'h0F);
        for (int k = 0; k < 8; k++) begin
            bus_rd(3'd1, d); chk("R6 kept bytes", d, 32'(8'h80 + k) << 8);
        end
        bus_rd(3'd1, d); chk("R6 last dropped", d, 32'h0);
        bus_rd(3'd2, d); chk("R6 sticky", d, 32'h0B);
        bus_wr(3'd2, 32'h0F);
        bus_rd(3'd2, d); chk("R7 ovf cleared", d, 32'h03);
        bus_rd(3'd0, d); chk("R7 live flags remain", d, 32'h03);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        bus_wr(3'd0, 32'h4F);
        bus_rd(3'd0, d); chk("R8 mask load", d, 32'h43);
        chk("R9 idle", 32'(irq), 0);
        rx_offer(8'h3C);
        @(negedge clk); chk("R10 not yet latched", 32'(irq), 0);
        @(negedge clk); chk("R9 R10 irq up", 32'(irq), 1);
        bus_rd(3'd1, d); chk("R4 irq byte", d, 32'h0000_3C00);
        bus_wr(3'd2, 32'h04);
        chk("R7 rxne clear", 32'(irq), 0);
        bus_wr(3'd0, 32'h10);
        chk("R9 txe enabled", 32'(irq), 1);
        bus_wr(3'd0, 32'h00);
        chk("R9 all masked", 32'(irq), 0);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        bus_wr(3'd5, 32'hFFFF_FFFF);
        bus_wr(3'd3, 32'hFFFF_FFFF);
        bus_rd(3'd5, d); chk("R11 word5", d, 32'h0);
        bus_rd(3'd3, d); chk("R11 word3", d, 32'h0);
        bus_rd(3'd7, d); chk("R11 word7", d, 32'h0);
        bus_rd(3'd0, d); chk("R11 intr untouched", d, 32'h03);
        bus_rd(3'd2, d); chk("R11 status untouched", d, 32'h03);
        chk("R11 tx untouched", 32'(ctl_tx_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_tx_order();
        t_tx_full();
        t_rx_basic();
        t_rx_overflow();
        t_irq();
        t_reserved();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule